// File: doc/BRIEF.md
# Machine-Check Error Bank Logger

This block keeps a small array of hardware error-reporting banks and decides, for each injected error record, what happens to it. Each bank has a control word, a status word, an address word and a miscellaneous word, all 64 bits wide. The block also holds a global status word. Two global settings arrive as static configuration inputs: a capability word, whose low byte gives the bank count and whose bit 8 says a global control word is present, and that global control word itself. A separate enable input allows machine-check delivery.

An injection request carries a bank index, a status word, a global status word, an address, a misc word and an unconditional flag. One cycle later the block answers with accept or reject and a reason code. Depending on the request, it may also update the bank, pulse a machine-check interrupt, or pulse a shutdown request. Corrected and uncorrected errors are handled on separate paths. When the target bank already holds a valid entry, the new record either overwrites it with the overflow bit set, or leaves it in place and only marks overflow. A combinational read port exposes every bank word and the global status.

Status bit positions used throughout: bit 63 valid, bit 62 overflow, bit 61 uncorrected, bit 55 action-required. In the global status word, bit 2 means a check is in progress. Response codes: 0 logged, 1 unsupported, 2 bad bank, 3 bad status, 4 ignored, 5 disabled, 6 shutdown, 7 merged (overflow marked only).

Top module: `mcb_logger`

## Requirements
- R1: After reset, resp_valid, mce_irq and shutdown_req are 0, and every bank status, address and misc word and the global status read 0.
- R2: A request made while the capability word is zero is rejected with code 1 (unsupported) and changes no state.
- R3: A request whose bank index is not below capability bits 7:0, or not below NUM_BANKS, is rejected with code 2 (bad bank).
- R4: A request whose status bit 63 is 0 is rejected with code 3 (bad status) and leaves the bank unchanged.
- R5: When global status bit 2 is set, a request is rejected with code 4 (ignored) unless its status bit 55 or its unconditional flag is set.
- R6: An uncorrected request (status bit 61 set) is rejected with code 5 (disabled) when capability bit 8 is set and the global control word is not all ones, or when the bank's control word is not all ones. A global control word that is not all ones has no effect when capability bit 8 is 0, and a bank control word that is not all ones has no effect on corrected requests.
- R7: An uncorrected request that passes R6 is rejected with code 6 while global status bit 2 is set or mce_en is 0. In that case shutdown_req pulses for one cycle and no bank or global status changes.
- R8: A logged uncorrected request writes the bank's address and misc words and the global status. It writes the bank status as the new status, with bit 62 set when the old status had bit 63 set. mce_irq pulses for one cycle and the code is 0.
- R9: A corrected request aimed at a bank whose status is invalid, or valid but not uncorrected, overwrites status, address and misc. Bit 62 is set when the old status was valid. The code is 0 and global status is untouched.
- R10: A corrected request aimed at a bank holding a valid uncorrected entry keeps that entry and only sets its bit 62. The request is accepted with code 7.
- R11: Every request gets exactly one response, one cycle after it is presented, and there is no response otherwise. A rejected request leaves the global status unchanged.
- R12: The read port returns, for rd_sel 0/1/2/3, the bank's control, status, address or misc word. A bank index of NUM_BANKS or more reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cap_i | input | 64 | Capability word (bits 7:0 bank count, bit 8 global control present) |
| gctl_i | input | 64 | Global control word |
| mce_en_i | input | 1 | Machine-check delivery enable |
| bank_ctl_i | input | 64*NUM_BANKS | Per-bank control words, bank 0 in the low bits |
| inj_valid | input | 1 | Injection request strobe |
| inj_bank | input | 8 | Target bank index |
| inj_status | input | 64 | Error status word |
| inj_gstat | input | 64 | Global status to store on an uncorrected log |
| inj_addr | input | 64 | Error address word |
| inj_misc | input | 64 | Error misc word |
| inj_uncond | input | 1 | Bypass the in-progress ignore rule |
| resp_valid | output | 1 | Response strobe |
| resp_accept | output | 1 | Request accepted (code 0 or 7) |
| resp_code | output | 3 | Reason code |
| mce_irq | output | 1 | Machine-check interrupt pulse |
| shutdown_req | output | 1 | Shutdown request pulse |
| rd_bank | input | 8 | Read bank index |
| rd_sel | input | 2 | Read word select |
| rd_data | output | 64 | Read data |
| gstat_o | output | 64 | Global status word |

## Verification
The bench builds the block with NUM_BANKS at its default of 4. It switches the capability count between 3 and 8, so that both the capability-limited index and an index past the physical banks can be hit with one build. The in-progress bit is set through a logged uncorrected error, which puts the ignored, unconditional, action-required and shutdown paths within reach. A mid-run reset clears the in-progress bit again, so the disabled and enable-off paths can be checked from a clean global status.

// File: rtl/mcb_pkg.sv
package mcb_pkg;
    localparam int REG_W      = 64;
    localparam int IDX_W      = 8;
    localparam int ST_VALID   = 63;
    localparam int ST_OVER    = 62;
    localparam int ST_UNCORR  = 61;
    localparam int ST_ACTREQ  = 55;
    localparam int GS_INPROG  = 2;
    localparam int CAP_GCTL_P = 8;

    typedef enum logic [2:0] {
        RC_LOGGED   = 3'd0,
        RC_UNSUP    = 3'd1,
        RC_BADBANK  = 3'd2,
        RC_BADSTAT  = 3'd3,
        RC_IGNORED  = 3'd4,
        RC_DISABLED = 3'd5,
        RC_SHUTDOWN = 3'd6,
        RC_MERGED   = 3'd7
    } resp_code_e;

    typedef enum logic [1:0] {
        SEL_CTL    = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_ADDR   = 2'd2,
        SEL_MISC   = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/mcb_screen.sv
module mcb_screen
    import mcb_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  logic [REG_W-1:0] cap,
    input  logic [REG_W-1:0] gctl,
    input  logic             mce_en,
    input  logic [REG_W-1:0] bank_ctl,
    input  logic [IDX_W-1:0] idx,
    input  logic [REG_W-1:0] status,
    input  logic             uncond,
    input  logic             in_prog,
    output resp_code_e       code,
    output logic             go
);
    logic idx_over_cap;
    logic idx_over_hw;
    logic uc_blocked;

    always_comb begin
        idx_over_cap = (idx >= cap[7:0]);
        idx_over_hw  = (32'(idx) >= NUM_BANKS);
        uc_blocked   = (cap[CAP_GCTL_P] && (gctl != '1)) || (bank_ctl != '1);
        code         = RC_LOGGED;
        go           = 1'b0;
        if (cap == '0) begin
            code = RC_UNSUP;
        end else if (idx_over_cap || idx_over_hw) begin
            code = RC_BADBANK;
        end else if (!status[ST_VALID]) begin
            code = RC_BADSTAT;
        end else if (!uncond && !status[ST_ACTREQ] && in_prog) begin
            code = RC_IGNORED;
        end else if (status[ST_UNCORR]) begin
            if (uc_blocked) begin
                code = RC_DISABLED;
            end else if (in_prog || !mce_en) begin
                code = RC_SHUTDOWN;
            end else begin
                go = 1'b1;
            end
        end else begin
            go = 1'b1;
        end
    end
endmodule

// File: rtl/mcb_merge.sv
module mcb_merge
    import mcb_pkg::*;
(
    input  logic [REG_W-1:0] old_status,
    input  logic [REG_W-1:0] new_status,
    output logic [REG_W-1:0] next_status,
    output logic             wr_entry,
    output logic             merged
);
    logic [REG_W-1:0] over_bit;
    logic             keep_old;

    always_comb begin
        over_bit = '0;
        over_bit[ST_OVER] = old_status[ST_VALID];
        keep_old = !new_status[ST_UNCORR]
                   && old_status[ST_VALID] && old_status[ST_UNCORR];
        if (keep_old) begin
            next_status = old_status | over_bit;
            wr_entry    = 1'b0;
            merged      = 1'b1;
        end else begin
            next_status = new_status | over_bit;
            wr_entry    = 1'b1;
            merged      = 1'b0;
        end
    end
endmodule

// File: rtl/mcb_readmux.sv
module mcb_readmux
    import mcb_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  logic [NUM_BANKS*REG_W-1:0]      ctl_flat,
    input  logic [NUM_BANKS-1:0][REG_W-1:0] st,
    input  logic [NUM_BANKS-1:0][REG_W-1:0] addr,
    input  logic [NUM_BANKS-1:0][REG_W-1:0] misc,
    input  logic [IDX_W-1:0]                bank,
    input  logic [1:0]                      sel,
    output logic [REG_W-1:0]                data
);
    logic [NUM_BANKS-1:0][REG_W-1:0] per_bank;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        always_comb begin
            unique case (reg_sel_e'(sel))
                SEL_CTL:    per_bank[b] = ctl_flat[b*REG_W +: REG_W];
                SEL_STATUS: per_bank[b] = st[b];
                SEL_ADDR:   per_bank[b] = addr[b];
                default:    per_bank[b] = misc[b];
            endcase
        end
    end

    always_comb begin
        data = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (32'(bank) == b) data = per_bank[b];
        end
    end
endmodule

// File: rtl/mcb_logger.sv
module mcb_logger
    import mcb_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [63:0]                cap_i,
    input  logic [63:0]                gctl_i,
    input  logic                       mce_en_i,
    input  logic [NUM_BANKS*64-1:0]    bank_ctl_i,
    input  logic                       inj_valid,
    input  logic [7:0]                 inj_bank,
    input  logic [63:0]                inj_status,
    input  logic [63:0]                inj_gstat,
    input  logic [63:0]                inj_addr,
    input  logic [63:0]                inj_misc,
    input  logic                       inj_uncond,
    output logic                       resp_valid,
    output logic                       resp_accept,
    output logic [2:0]                 resp_code,
    output logic                       mce_irq,
    output logic                       shutdown_req,
    input  logic [7:0]                 rd_bank,
    input  logic [1:0]                 rd_sel,
    output logic [63:0]                rd_data,
    output logic [63:0]                gstat_o
);
    localparam int SEL_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

    typedef struct packed {
        logic [NUM_BANKS-1:0][REG_W-1:0] st;
        logic [NUM_BANKS-1:0][REG_W-1:0] addr;
        logic [NUM_BANKS-1:0][REG_W-1:0] misc;
        logic [REG_W-1:0]                gstat;
        logic                            resp_v;
        logic                            resp_acc;
        resp_code_e                      code;
        logic                            irq;
        logic                            shut;
    } state_t;

    state_t state_d, state_q;

    logic [SEL_W-1:0] bsel;
    logic [REG_W-1:0] sel_ctl;
    logic [REG_W-1:0] sel_old_st;
    resp_code_e       scr_code;
    logic             scr_go;
    logic [REG_W-1:0] mrg_status;
    logic             mrg_wr;
    logic             mrg_merged;

    always_comb begin
        bsel       = (32'(inj_bank) < NUM_BANKS) ? SEL_W'(inj_bank) : '0;
        sel_ctl    = bank_ctl_i[32'(bsel)*REG_W +: REG_W];
        sel_old_st = state_q.st[bsel];
    end

    mcb_screen #(.NUM_BANKS(NUM_BANKS)) u_screen (
        .cap      (cap_i),
        .gctl     (gctl_i),
        .mce_en   (mce_en_i),
        .bank_ctl (sel_ctl),
        .idx      (inj_bank),
        .status   (inj_status),
        .uncond   (inj_uncond),
        .in_prog  (state_q.gstat[GS_INPROG]),
        .code     (scr_code),
        .go       (scr_go)
    );

    mcb_merge u_merge (
        .old_status  (sel_old_st),
        .new_status  (inj_status),
        .next_status (mrg_status),
        .wr_entry    (mrg_wr),
        .merged      (mrg_merged)
    );

    always_comb begin
        state_d          = state_q;
        state_d.resp_v   = inj_valid;
        state_d.resp_acc = 1'b0;
        state_d.irq      = 1'b0;
        state_d.shut     = 1'b0;
        state_d.code     = RC_LOGGED;
        if (inj_valid) begin
            state_d.code = scr_code;
            state_d.shut = (scr_code == RC_SHUTDOWN);
            if (scr_go) begin
                state_d.resp_acc  = 1'b1;
                state_d.code      = mrg_merged ? RC_MERGED : RC_LOGGED;
                state_d.st[bsel]  = mrg_status;
                if (mrg_wr) begin
                    state_d.addr[bsel] = inj_addr;
                    state_d.misc[bsel] = inj_misc;
                end
                if (inj_status[ST_UNCORR]) begin
                    state_d.gstat = inj_gstat;
                    state_d.irq   = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    mcb_readmux #(.NUM_BANKS(NUM_BANKS)) u_rd (
        .ctl_flat (bank_ctl_i),
        .st       (state_q.st),
        .addr     (state_q.addr),
        .misc     (state_q.misc),
        .bank     (rd_bank),
        .sel      (rd_sel),
        .data     (rd_data)
    );

    assign resp_valid   = state_q.resp_v;
    assign resp_accept  = state_q.resp_acc;
    assign resp_code    = state_q.code;
    assign mce_irq      = state_q.irq;
    assign shutdown_req = state_q.shut;
    assign gstat_o      = state_q.gstat;
endmodule

// File: rtl/mcb_logger_chk.sv
module mcb_logger_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        inj_valid,
    input logic        resp_valid,
    input logic        resp_accept,
    input logic [2:0]  resp_code,
    input logic        mce_irq,
    input logic        shutdown_req,
    input logic [63:0] gstat_o
);
    // R11
    resp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inj_valid |=> resp_valid);

    // R11
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inj_valid |=> !resp_valid);

    // R8
    irq_on_log_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mce_irq |-> (resp_valid && resp_accept && resp_code == 3'd0));

    // R7
    shutdown_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |-> (resp_valid && !resp_accept && resp_code == 3'd6 && $stable(gstat_o)));

    // R11
    reject_keeps_gstat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_accept) |-> $stable(gstat_o));

    // R10
    accept_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_accept) |-> (resp_code == 3'd0 || resp_code == 3'd7));

    // R7
    irq_shut_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mce_irq, shutdown_req}));
endmodule

bind mcb_logger mcb_logger_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .inj_valid    (inj_valid),
    .resp_valid   (resp_valid),
    .resp_accept  (resp_accept),
    .resp_code    (resp_code),
    .mce_irq      (mce_irq),
    .shutdown_req (shutdown_req),
    .gstat_o      (gstat_o)
);

// File: tb/sim_mcb_logger.sv
`timescale 1ns/1ps
module sim_mcb_logger;
    localparam int NB = 4;
    localparam logic [63:0] V  = 64'h8000_0000_0000_0000;
    localparam logic [63:0] OV = 64'h4000_0000_0000_0000;
    localparam logic [63:0] UC = 64'h2000_0000_0000_0000;
    localparam logic [63:0] AR = 64'h0080_0000_0000_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [63:0] cap_i = '0, gctl_i = '0;
    logic mce_en_i = 1'b0;
    logic [NB*64-1:0] bank_ctl_i = '1;
    logic inj_valid = 1'b0;
    logic [7:0] inj_bank = '0;
    logic [63:0] inj_status = '0, inj_gstat = '0, inj_addr = '0, inj_misc = '0;
    logic inj_uncond = 1'b0;
    logic resp_valid, resp_accept, mce_irq, shutdown_req;
    logic [2:0] resp_code;
    logic [7:0] rd_bank = '0;
    logic [1:0] rd_sel = '0;
    logic [63:0] rd_data, gstat_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    mcb_logger #(.NUM_BANKS(NB)) u0 (
        .clk(clk), .rst_n(rst_n), .cap_i(cap_i), .gctl_i(gctl_i),
        .mce_en_i(mce_en_i), .bank_ctl_i(bank_ctl_i), .inj_valid(inj_valid),
        .inj_bank(inj_bank), .inj_status(inj_status), .inj_gstat(inj_gstat),
        .inj_addr(inj_addr), .inj_misc(inj_misc), .inj_uncond(inj_uncond),
        .resp_valid(resp_valid), .resp_accept(resp_accept), .resp_code(resp_code),
        .mce_irq(mce_irq), .shutdown_req(shutdown_req), .rd_bank(rd_bank),
        .rd_sel(rd_sel), .rd_data(rd_data), .gstat_o(gstat_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] b, input logic [1:0] s, output logic [63:0] v);
        rd_bank = b;
        rd_sel  = s;
        #0.5;
        v = rd_data;
    endtask

    // Presents one request, then samples the response one cycle later.
    task automatic inject(input string req, input logic [7:0] b, input logic [63:0] st,
                          input logic [63:0] gs, input logic [63:0] a, input logic [63:0] m,
                          input logic unc, input logic acc, input logic [2:0] code,
                          input logic irq, input logic shut);
        @(negedge clk);
        inj_bank = b; inj_status = st; inj_gstat = gs;
        inj_addr = a; inj_misc = m; inj_uncond = unc; inj_valid = 1'b1;
        @(negedge clk);
        inj_valid = 1'b0; inj_uncond = 1'b0;
        chk({req, " resp_valid"}, 64'(resp_valid), 64'd1);
        chk({req, " accept"}, 64'(resp_accept), 64'(acc));
        chk({req, " code"}, 64'(resp_code), 64'(code));
        chk({req, " irq"}, 64'(mce_irq), 64'(irq));
        chk({req, " shutdown"}, 64'(shutdown_req), 64'(shut));
    endtask

    task automatic t_reset();
        logic [63:0] v;
        chk("R1 resp_valid", 64'(resp_valid), 0);
        chk("R1 irq", 64'(mce_irq), 0);
        chk("R1 shutdown", 64'(shutdown_req), 0);
        chk("R1 gstat", gstat_o, 0);
        for (int b = 0; b < NB; b++) begin
            rd(8'(b), 2'd1, v); chk("R1 status", v, 0);
            rd(8'(b), 2'd2, v); chk("R1 addr", v, 0);
        end
    endtask

    task automatic t_unsup();
        logic [63:0] v;
        cap_i = '0;
        inject("R2", 8'd0, V | 64'h1, 64'h1, 64'h10, 64'h20, 1'b0, 1'b0, 3'd1, 1'b0, 1'b0);
        @(negedge clk);
        chk("R11 single response", 64'(resp_valid), 0);
        rd(8'd0, 2'd1, v); chk("R2 bank untouched", v, 0);
        cap_i = 64'h103;
    endtask

    task automatic t_badbank();
        inject("R3 cap limit", 8'd3, V | 64'h1, 0, 0, 0, 1'b0, 1'b0, 3'd2, 1'b0, 1'b0);
        cap_i = 64'h108;
        inject("R3 hw limit", 8'd5, V | 64'h1, 0, 0, 0, 1'b0, 1'b0, 3'd2, 1'b0, 1'b0);
        cap_i = 64'h103;
    endtask

    task automatic t_badstat();
        logic [63:0] v;
        inject("R4", 8'd0, 64'h11, 0, 64'h99, 0, 1'b0, 1'b0, 3'd3, 1'b0, 1'b0);
        rd(8'd0, 2'd1, v); chk("R4 bank untouched", v, 0);
    endtask

    task automatic t_corrected();
        logic [63:0] v;
        inject("R9 first", 8'd0, V | 64'h11, 64'hF, 64'h1000, 64'hAA, 1'b0, 1'b1, 3'd0, 1'b0, 1'b0);
        rd(8'd0, 2'd1, v); chk("R9 status", v, V | 64'h11);
        rd(8'd0, 2'd2, v); chk("R9 addr", v, 64'h1000);
        rd(8'd0, 2'd3, v); chk("R9 misc", v, 64'hAA);
        chk("R9 gstat untouched", gstat_o, 0);
        inject("R9 overwrite", 8'd0, V | 64'h22, 0, 64'h2000, 64'hBB, 1'b0, 1'b1, 3'd0, 1'b0, 1'b0);
        rd(8'd0, 2'd1, v); chk("R9 overflow status", v, V | OV | 64'h22);
        rd(8'd0, 2'd2, v); chk("R9 overwrite addr", v, 64'h2000);
    endtask

    task automatic t_uncorrected();
        logic [63:0] v;
        inject("R8 first", 8'd1, V | UC | 64'h33, 64'h1, 64'h3000, 64'hCC, 1'b0, 1'b1, 3'd0, 1'b1, 1'b0);
        rd(8'd1, 2'd1, v); chk("R8 status", v, V | UC | 64'h33);
        rd(8'd1, 2'd2, v); chk("R8 addr", v, 64'h3000);
        rd(8'd1, 2'd3, v); chk("R8 misc", v, 64'hCC);
        chk("R8 gstat", gstat_o, 64'h1);
        @(negedge clk);
        chk("R8 irq one cycle", 64'(mce_irq), 0);
        inject("R10 merge", 8'd1, V | 64'h44, 0, 64'h4000, 64'hDD, 1'b0, 1'b1, 3'd7, 1'b0, 1'b0);
        rd(8'd1, 2'd1, v); chk("R10 status kept", v, V | UC | OV | 64'h33);
        rd(8'd1, 2'd2, v); chk("R10 addr kept", v, 64'h3000);
        inject("R8 over", 8'd1, V | UC | 64'h55, 64'h5, 64'h5000, 64'hEE, 1'b0, 1'b1, 3'd0, 1'b1, 1'b0);
        rd(8'd1, 2'd1, v); chk("R8 over status", v, V | UC | OV | 64'h55);
        chk("R8 gstat in-progress", gstat_o, 64'h5);
    endtask

    task automatic t_in_progress();
        logic [63:0] v;
        inject("R5 uc ignored", 8'd2, V | UC | 64'h66, 0, 0, 0, 1'b0, 1'b0, 3'd4, 1'b0, 1'b0);
        inject("R5 corr ignored", 8'd2, V | 64'h77, 0, 0, 0, 1'b0, 1'b0, 3'd4, 1'b0, 1'b0);
        rd(8'd2, 2'd1, v); chk("R5 bank untouched", v, 0);
        inject("R7 in-progress", 8'd2, V | UC | AR | 64'h88, 0, 64'h1, 0, 1'b0, 1'b0, 3'd6, 1'b0, 1'b1);
        rd(8'd2, 2'd1, v); chk("R7 bank untouched", v, 0);
        chk("R7 gstat kept", gstat_o, 64'h5);
        inject("R5 uncond", 8'd2, V | 64'h99, 0, 64'h9000, 0, 1'b1, 1'b1, 3'd0, 1'b0, 1'b0);
        rd(8'd2, 2'd1, v); chk("R5 uncond status", v, V | 64'h99);
        inject("R5 action-req", 8'd2, V | AR | 64'hAA, 0, 64'hA000, 0, 1'b0, 1'b1, 3'd0, 1'b0, 1'b0);
        rd(8'd2, 2'd1, v); chk("R5 action-req status", v, V | AR | OV | 64'hAA);
    endtask

    task automatic t_disabled();
        logic [63:0] v;
        do_reset();
        chk("R1 gstat after reset", gstat_o, 0);
        rd(8'd1, 2'd1, v); chk("R1 status after reset", v, 0);
        cap_i = 64'h103; gctl_i = '0;
        inject("R6 gctl", 8'd0, V | UC | 64'h11, 0, 0, 0, 1'b0, 1'b0, 3'd5, 1'b0, 1'b0);
        rd(8'd0, 2'd1, v); chk("R6 bank untouched", v, 0);
        cap_i = 64'h003;
        inject("R6 gctl absent", 8'd0, V | UC | 64'h11, 0, 64'h11, 0, 1'b0, 1'b1, 3'd0, 1'b1, 1'b0);
        rd(8'd0, 2'd1, v); chk("R6 logged", v, V | UC | 64'h11);
        bank_ctl_i[64 +: 64] = '0;
        inject("R6 bank ctl", 8'd1, V | UC | 64'h12, 0, 0, 0, 1'b0, 1'b0, 3'd5, 1'b0, 1'b0);
        inject("R6 corr passes", 8'd1, V | 64'h12, 0, 0, 0, 1'b0, 1'b1, 3'd0, 1'b0, 1'b0);
        rd(8'd1, 2'd0, v); chk("R12 ctl read", v, 0);
        bank_ctl_i = '1;
        mce_en_i = 1'b0;
        inject("R7 enable off", 8'd2, V | UC | 64'h13, 0, 0, 0, 1'b0, 1'b0, 3'd6, 1'b0, 1'b1);
        rd(8'd2, 2'd1, v); chk("R7 enable off untouched", v, 0);
        mce_en_i = 1'b1;
    endtask

    task automatic t_readport();
        logic [63:0] v;
        rd(8'd1, 2'd0, v); chk("R12 ctl", v, '1);
        rd(8'd1, 2'd1, v); chk("R12 status", v, V | 64'h12);
        rd(8'd0, 2'd2, v); chk("R12 addr", v, 64'h11);
        rd(8'd4, 2'd0, v); chk("R12 out of range", v, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        gctl_i = '1; mce_en_i = 1'b1; bank_ctl_i = '1;
        t_unsup();
        t_badbank();
        t_badstat();
        t_corrected();
        t_uncorrected();
        t_in_progress();
        t_disabled();
        t_readport();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule